// File: doc/BRIEF.md
# Cartridge Header Validator

This block checks a game cartridge image while the ROM contents stream past it, one byte per accepted beat, each beat carrying its own byte address. It compares a four-byte signature at the front of the image, captures the 16-bit checksum stored just after it, and decodes the region and ROM-size codes from the following byte. Every byte that lies past the 30-byte header and below the decoded image size is added into a wrapping 16-bit sum. When the last byte of the image is taken, the block raises `done` together with exactly one of `img_ok` or `img_bad`, and holds that verdict, the region code, the decoded size and the raw header bytes until the next `start`.

The byte input is a valid/ready stream. `in_ready` is low while the block sits idle after reset, and goes high on the cycle after `start`. From then on it never drops, so the producer sees no back-pressure. A beat is taken on any cycle where `in_valid` and `in_ready` are both high. Bytes taken after the verdict are drained and discarded. `start` and `in_eos` are plain control pulses. `in_eos` tells the block that the stream has ended, whether or not a beat arrives in that cycle.

Top module: `cart_hdr_check`

## Requirements
- R1: After reset, `done`, `img_ok` and `img_bad` are low. A `start` pulse clears them on the next cycle, and a `start` during a run abandons that run and begins a new one.
- R2: The bytes at addresses 0, 1, 2 and 3 must be 0x56, 0x47, 0x53 and 0x20. Any mismatch ends with `img_bad`.
- R3: The stored checksum is taken from address 4 (low byte) and address 5 (high byte). If the computed sum differs from it, the result is `img_bad`.
- R4: The computed sum is the 16-bit wrapping sum of the bytes at addresses 30 up to the decoded size minus one. Header bytes at addresses 0 to 29 are never added.
- R5: The byte at address 6 holds the region in bits 7:4 and the size code in bits 3:0. `region` shows bits 7:4. `rom_bytes` shows the size in bytes for codes 0 to 15: 4, 8, 16, 24, 32, 48, 64, 128, 256, 384, 512, 768, 1024, 1536, 2048 and 4096 KiB. Before address 6 has been taken, `rom_bytes` and `region` are zero.
- R6: `done` rises on the cycle after the byte at address size−1 is taken. While `done` is high, exactly one of `img_ok`/`img_bad` is high. While `done` is low, both are low.
- R7: Bytes taken after `done` are accepted and ignored: the verdict and every other output stay unchanged.
- R8: `in_eos` during a run that has not yet taken its final byte ends the run on the next cycle with `done` and `img_bad`.
- R9: `in_eos` in the same cycle as the final byte does not override that byte. The verdict follows the signature and checksum.
- R10: After `done`, `img_ok`, `img_bad`, `region`, `rom_bytes` and `hdr_raw` hold their values until `start`.
- R11: `hdr_raw` carries the bytes at addresses 7 to 29 as taken. The byte at address 7 is in bits 7:0, and each later address sits 8 bits higher.
- R12: `in_ready` is low from reset until the first `start`, and is high in every cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the result and begins a new image |
| in_valid | input | 1 | Byte beat offered |
| in_ready | output | 1 | Block accepts beats |
| in_data | input | 8 | Byte value |
| in_addr | input | ADDR_W (22) | Byte address within the image |
| in_eos | input | 1 | End of stream marker |
| done | output | 1 | Verdict available |
| img_ok | output | 1 | Image passed all checks |
| img_bad | output | 1 | Image failed a check or ended early |
| region | output | 4 | Region code from the header |
| rom_bytes | output | ADDR_W+1 (23) | Decoded image size in bytes |
| hdr_raw | output | 184 | Raw header bytes, addresses 7 to 29 |

## Verification
The case that needs care is the final byte of the image arriving in the same cycle as the end-of-stream marker. The block must finish the sum with that byte and judge the checksum, rather than treat the run as cut short. The bench provokes this twice: once with a correct checksum on an 8 KiB image with idle gaps, where `img_ok` is expected, and once with a corrupted checksum, where `img_bad` is expected. A separate run raises the marker well before the size is reached, and there `img_bad` is required.

// File: rtl/cartval_pkg.sv
package cartval_pkg;

  localparam int HDR_LEN    = 30;
  localparam int SIG_BYTES  = 4;
  localparam int POS_SUM_LO = 4;
  localparam int POS_SUM_HI = 5;
  localparam int POS_INFO   = 6;
  localparam int RAW_FIRST  = 7;
  localparam int RAW_BYTES  = HDR_LEN - RAW_FIRST;
  localparam int CSUM_W     = 16;
  localparam int KIB_W      = 13;
  localparam int KIB_SHIFT  = 10;

  // signature, address 0 in the lowest byte
  localparam logic [8*SIG_BYTES-1:0] SIG_WORD = 32'h2053_4756;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cv_state_e;

  function automatic logic [KIB_W-1:0] size_kib(input logic [3:0] code);
    logic [KIB_W-1:0] k;
    unique case (code)
      4'h0: k = 13'd4;
      4'h1: k = 13'd8;
      4'h2: k = 13'd16;
      4'h3: k = 13'd24;
      4'h4: k = 13'd32;
      4'h5: k = 13'd48;
      4'h6: k = 13'd64;
      4'h7: k = 13'd128;
      4'h8: k = 13'd256;
      4'h9: k = 13'd384;
      4'hA: k = 13'd512;
      4'hB: k = 13'd768;
      4'hC: k = 13'd1024;
      4'hD: k = 13'd1536;
      4'hE: k = 13'd2048;
      default: k = 13'd4096;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cartval_hdr.sv
// Header field capture: signature match, stored checksum, info byte, raw bytes.
module cartval_hdr
  import cartval_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   take,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             data,
  output logic                   sig_ok,
  output logic [CSUM_W-1:0]      stored_sum,
  output logic [3:0]             region_code,
  output logic [3:0]             size_code,
  output logic                   have_info,
  output logic [8*RAW_BYTES-1:0] raw
);

  logic [SIG_BYTES-1:0] sig_hit;

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
    logic hit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit <= 1'b0;
      end else if (clear) begin
        hit <= 1'b0;
      end else if (take && addr == ADDR_W'(g)) begin
        hit <= (data == SIG_WORD[8*g +: 8]);
      end
    end
    assign sig_hit[g] = hit;
  end

  assign sig_ok = &sig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_sum  <= '0;
      region_code <= '0;
      size_code   <= '0;
      have_info   <= 1'b0;
    end else if (clear) begin
      stored_sum  <= '0;
      region_code <= '0;
      size_code   <= '0;
      have_info   <= 1'b0;
    end else if (take) begin
      if (addr == ADDR_W'(POS_SUM_LO)) stored_sum[7:0]  <= data;
      if (addr == ADDR_W'(POS_SUM_HI)) stored_sum[15:8] <= data;
      if (addr == ADDR_W'(POS_INFO)) begin
        region_code <= data[7:4];
        size_code   <= data[3:0];
        have_info   <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < RAW_BYTES; g++) begin : g_raw
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (clear) begin
        byte_q <= '0;
      end else if (take && addr == ADDR_W'(RAW_FIRST + g)) begin
        byte_q <= data;
      end
    end
    assign raw[8*g +: 8] = byte_q;
  end

endmodule

// File: rtl/cartval_acc.sv
// Wrapping checksum over the body bytes below the decoded size.
module cartval_acc
  import cartval_pkg::*;
#(
  parameter int ADDR_W = 22,
  localparam int SIZE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [SIZE_W-1:0] limit,
  output logic [CSUM_W-1:0] sum_nxt
);

  logic [CSUM_W-1:0] sum_q;
  logic [SIZE_W-1:0] addr_w;
  logic              in_body;

  assign addr_w  = {1'b0, addr};
  assign in_body = (addr_w >= SIZE_W'(HDR_LEN)) && (addr_w < limit);
  assign sum_nxt = sum_q + CSUM_W'(in_body ? data : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (clear) begin
      sum_q <= '0;
    end else if (take) begin
      sum_q <= sum_nxt;
    end
  end

endmodule

// File: rtl/cartval_seq.sv
// Run control and verdict registers.
module cartval_seq
  import cartval_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      take,
  input  logic      eos,
  input  logic      last_hit,
  input  logic      sig_ok,
  input  logic      sum_match,
  output cv_state_e st,
  output logic      done,
  output logic      ok,
  output logic      bad
);

  logic verdict;
  assign verdict = sig_ok && sum_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
      ok   <= 1'b0;
      bad  <= 1'b0;
    end else if (start) begin
      st   <= ST_RUN;
      done <= 1'b0;
      ok   <= 1'b0;
      bad  <= 1'b0;
    end else if (st == ST_RUN) begin
      if (take && last_hit) begin
        st   <= ST_DONE;
        done <= 1'b1;
        ok   <= verdict;
        bad  <= !verdict;
      end else if (eos) begin
        st   <= ST_DONE;
        done <= 1'b1;
        ok   <= 1'b0;
        bad  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cart_hdr_check.sv
module cart_hdr_check
  import cartval_pkg::*;
#(
  parameter int ADDR_W = 22,
  localparam int SIZE_W = ADDR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic                   in_eos,
  output logic                   done,
  output logic                   img_ok,
  output logic                   img_bad,
  output logic [3:0]             region,
  output logic [SIZE_W-1:0]      rom_bytes,
  output logic [8*RAW_BYTES-1:0] hdr_raw
);

  cv_state_e         st;
  logic              take;
  logic              sig_ok;
  logic [CSUM_W-1:0] stored_sum;
  logic [CSUM_W-1:0] sum_nxt;
  logic [3:0]        size_code;
  logic              have_info;
  logic [KIB_W-1:0]  kib;
  logic [SIZE_W-1:0] limit;
  logic              last_hit;

  // beats are only processed while a run is open and no restart is pending
  assign take     = in_valid && (st == ST_RUN) && !start;
  assign in_ready = (st != ST_IDLE);

  cartval_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start),
    .take        (take),
    .addr        (in_addr),
    .data        (in_data),
    .sig_ok      (sig_ok),
    .stored_sum  (stored_sum),
    .region_code (region),
    .size_code   (size_code),
    .have_info   (have_info),
    .raw         (hdr_raw)
  );

  assign kib      = size_kib(size_code);
  assign limit    = have_info ? (SIZE_W'(kib) << KIB_SHIFT) : '0;
  assign last_hit = have_info && ({1'b0, in_addr} == limit - SIZE_W'(1));

  cartval_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .take    (take),
    .addr    (in_addr),
    .data    (in_data),
    .limit   (limit),
    .sum_nxt (sum_nxt)
  );

  cartval_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .take      (take),
    .eos       (in_eos),
    .last_hit  (last_hit),
    .sig_ok    (sig_ok),
    .sum_match (sum_nxt == stored_sum),
    .st        (st),
    .done      (done),
    .ok        (img_ok),
    .bad       (img_bad)
  );

  assign rom_bytes = limit;

endmodule

// File: rtl/cartval_chk.sv
module cartval_chk
  import cartval_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   in_eos,
  input logic                   in_ready,
  input logic                   done,
  input logic                   img_ok,
  input logic                   img_bad,
  input logic [3:0]             region,
  input logic [ADDR_W:0]        rom_bytes,
  input logic [8*RAW_BYTES-1:0] hdr_raw
);

  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (img_ok ^ img_bad));

  a_r6_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!img_ok && !img_bad));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(img_ok) && $stable(img_bad) &&
                          $stable(region) && $stable(rom_bytes) && $stable(hdr_raw)));

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && in_ready));

  a_r8_eos_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (in_eos && in_ready && !done && !start) |=> done);

endmodule

bind cart_hdr_check cartval_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_eos    (in_eos),
  .in_ready  (in_ready),
  .done      (done),
  .img_ok    (img_ok),
  .img_bad   (img_bad),
  .region    (region),
  .rom_bytes (rom_bytes),
  .hdr_raw   (hdr_raw)
);

// File: tb/sim_cart_hdr_check.sv
`timescale 1ns/1ps
module sim_cart_hdr_check;
  import cartval_pkg::*;

  localparam int AW = 22;
  localparam int SW = AW + 1;
  localparam int RB = RAW_BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_eos = 1'b0;
  logic [7:0] in_data = '0;
  logic [AW-1:0] in_addr = '0;
  logic in_ready, done, img_ok, img_bad;
  logic [3:0] region;
  logic [SW-1:0] rom_bytes;
  logic [8*RB-1:0] hdr_raw;

  always #4 clk = ~clk;

  cart_hdr_check #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_addr(in_addr), .in_eos(in_eos),
    .done(done), .img_ok(img_ok), .img_bad(img_bad), .region(region),
    .rom_bytes(rom_bytes), .hdr_raw(hdr_raw)
  );

  int vectors = 0;
  int miss = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    vectors++;
    if (!good) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_kib(input int c);
    case (c)
      0: return 4;      1: return 8;      2: return 16;     3: return 24;
      4: return 32;     5: return 48;     6: return 64;     7: return 128;
      8: return 256;    9: return 384;    10: return 512;   11: return 768;
      12: return 1024;  13: return 1536;  14: return 2048;  default: return 4096;
    endcase
  endfunction

  function automatic int sig_byte(input int i);
    case (i)
      0: return 'h56; 1: return 'h47; 2: return 'h53; default: return 'h20;
    endcase
  endfunction

  function automatic int pat(input int a);
    return (a * 13 + (a >> 8) + 5) & 255;
  endfunction

  // ---------------- behavioural reference model ----------------
  int mst, msum, mstored, mreg, mcode, msize;
  bit mhave, mbadsig, mok;
  logic [7:0] mraw [RB];

  task automatic m_clear();
    msum = 0; mstored = 0; mreg = 0; mcode = 0; msize = 0;
    mhave = 0; mbadsig = 0; mok = 0;
    for (int i = 0; i < RB; i++) mraw[i] = 8'h00;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0;
      m_clear();
    end else if (start) begin
      mst = 1;
      m_clear();
    end else if (mst == 1) begin
      if (in_valid) begin
        int a, d;
        a = int'(in_addr);
        d = int'(in_data);
        if (a < 4 && d != sig_byte(a)) mbadsig = 1;
        if (a == 4) mstored = (mstored & 'hff00) | d;
        if (a == 5) mstored = (mstored & 'h00ff) | (d << 8);
        if (a == 6) begin mreg = d >> 4; mcode = d & 15; mhave = 1; end
        if (a >= 7 && a < 30) mraw[a - 7] = 8'(d);
        msize = mhave ? ref_kib(mcode) * 1024 : 0;
        if (a >= 30 && a < msize) msum = (msum + d) & 'hffff;
        if (mhave && a == msize - 1) begin
          mst = 2;
          mok = !mbadsig && (msum == mstored);
        end else if (in_eos) begin
          mst = 2; mok = 0;
        end
      end else if (in_eos) begin
        mst = 2; mok = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [8*RB-1:0] eraw;
      bit edone;
      edone = (mst == 2);
      for (int i = 0; i < RB; i++) eraw[8*i +: 8] = mraw[i];
      chk(done == edone, "R6 done", done, edone);
      chk(img_ok == (edone && mok), "R3 img_ok", img_ok, edone && mok);
      chk(img_bad == (edone && !mok), "R2 img_bad", img_bad, edone && !mok);
      chk(in_ready == (mst != 0), "R12 in_ready", in_ready, mst != 0);
      chk(int'(region) == mreg, "R5 region", region, mreg);
      chk(longint'(rom_bytes) == longint'(msize), "R5 rom_bytes", rom_bytes, msize);
      chk(hdr_raw == eraw, "R11 hdr_raw", hdr_raw[63:0], eraw[63:0]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic beat(input int a, input int d, input bit eos);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = AW'(a);
    in_data  = 8'(d);
    in_eos   = eos;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_eos   = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 1'b0; in_eos = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_hdr(input int code, input int rg);
    for (int a = 0; a < 7; a++)
      beat(a, (a < 4) ? sig_byte(a) : (a == 6 ? rg * 16 + code : 0), 1'b0);
    idle(1);
  endtask

  task automatic send_image(input int code, input int rg, input bit bad_sig, input bit bad_sum,
                            input int eos_at, input bit gaps, input int extra);
    int size, s, d;
    size = ref_kib(code) * 1024;
    s = 0;
    for (int a = 30; a < size; a++) s = (s + pat(a)) & 'hffff;
    if (bad_sum) s = (s + 1) & 'hffff;
    for (int a = 0; a < size; a++) begin
      if (a < 4) d = (bad_sig && a == 2) ? 'h54 : sig_byte(a);
      else if (a == 4) d = s & 255;
      else if (a == 5) d = s >> 8;
      else if (a == 6) d = rg * 16 + code;
      else d = pat(a);
      if (gaps && (a % 5 == 0)) idle(1);
      beat(a, d, a == eos_at);
      if (a == eos_at) break;
    end
    for (int k = 0; k < extra; k++) beat(size + k, pat(k), 1'b0);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && img_ok == 0 && img_bad == 0, "R1 reset outputs", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 0, "R12 idle refuses", in_ready, 0);
    pulse_start();
    chk(in_ready == 1, "R12 ready after start", in_ready, 1);

    // R5: every size code and region nibble
    for (int c = 0; c < 16; c++) begin
      send_hdr(c, 15 - c);
      chk(longint'(rom_bytes) == longint'(ref_kib(c)) * 1024, "R5 size table", rom_bytes, ref_kib(c) * 1024);
      chk(int'(region) == 15 - c, "R5 region nibble", region, 15 - c);
      pulse_start();
    end

    // good 4 KiB image
    send_image(0, 3, 0, 0, -1, 0, 0);
    chk(done && img_ok && !img_bad, "R4 body sum only, header excluded", img_ok, 1);
    chk(hdr_raw[7:0] == 8'(pat(7)), "R11 first raw byte", hdr_raw[7:0], pat(7));
    chk(hdr_raw[8*RB-1 -: 8] == 8'(pat(29)), "R11 last raw byte", hdr_raw[8*RB-1 -: 8], pat(29));
    idle(20);
    chk(done && img_ok && region == 4'd3, "R10 verdict held", img_ok, 1);
    pulse_start();
    chk(!done && !img_ok && !img_bad, "R1 start clears", done, 0);

    // corrupted signature
    send_image(0, 1, 1, 0, -1, 0, 0);
    chk(done && img_bad, "R2 signature mismatch", img_bad, 1);
    pulse_start();

    // corrupted checksum, with gaps
    send_image(0, 2, 0, 1, -1, 1, 0);
    chk(done && img_bad, "R3 checksum mismatch", img_bad, 1);
    pulse_start();

    // 8 KiB, gaps, eos with last byte, extra bytes after done
    send_image(1, 10, 0, 0, 8191, 1, 40);
    chk(done && img_ok, "R9 eos with final byte good", img_ok, 1);
    chk(longint'(rom_bytes) == 8192 && region == 4'hA, "R7 extra bytes ignored", rom_bytes, 8192);
    pulse_start();

    // early end
    send_image(0, 4, 0, 0, 2000, 0, 0);
    chk(done && img_bad, "R8 early end of stream", img_bad, 1);
    pulse_start();

    // eos with final byte, bad checksum
    send_image(0, 5, 0, 1, 4095, 0, 0);
    chk(done && img_bad, "R9 eos with final byte bad sum", img_bad, 1);
    pulse_start();

    // restart in the middle of a run
    send_hdr(0, 6);
    pulse_start();
    send_image(0, 7, 0, 0, -1, 0, 0);
    chk(done && img_ok && region == 4'd7, "R1 restart mid-run", img_ok, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miss++;
      $display("FAIL R6 watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

endmodule